// File: doc/BRIEF.md
# Frame Interrupt Pulse Generator

This block produces the periodic video-frame interrupt for an 8-bit microprocessor system that runs on the same clock. A divider counts CPU clocks and emits one frame tick per frame period. The period is 50 Hz by default, and a select input switches it to 60 Hz. Each tick opens a pulse of a fixed number of CPU clocks on the interrupt line. The line is active-low and shared with other sources through an external pull-up. The block therefore never drives it high: its output is an enable for a pad that pulls the line to 0, and the line is released at all other times.

The same tick also raises a pending flag so that software can tell this source apart from other interrupters. The port logic places the flag on bit 7 of the I/O port read data. A read strobe on the port clears the flag. A write strobe clears it only when the written byte is 0x80. If a tick and a clearing access arrive in the same cycle, the tick wins. Interrupt vector supply is handled elsewhere.

Top module: `frame_irq_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `int_oe` is 0 and `irq_flag` is 0.
- R2: With `rate_sel` = 0, pulse starts on `int_oe` are exactly CLK_HZ/50 clock cycles apart.
- R3: With `rate_sel` = 1, pulse starts on `int_oe` are exactly CLK_HZ/60 clock cycles apart.
- R4: Each pulse holds `int_oe` at 1 for exactly PULSE_CLKS consecutive cycles, then returns it to 0 (line released). PULSE_CLKS defaults to 32, which is at least 23.
- R5: `irq_flag` becomes 1 on the same clock edge on which `int_oe` rises.
- R6: A cycle with `port_rd` = 1 clears `irq_flag` on the next edge, unless a frame tick falls on that edge.
- R7: A cycle with `port_wr` = 1 and `port_wdata` = 0x80 clears `irq_flag`. A write of any other byte leaves it unchanged.
- R8: When a frame tick and a clearing access fall on the same edge, `irq_flag` is 1 afterwards.
- R9: If `rate_sel` shortens the period while the divider has already passed the new terminal count, the next pulse starts on the following edge.
- R10: After reset is released, the first pulse starts on the P-th clock edge, where P is the period selected by `rate_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | 0 selects 50 Hz frames, 1 selects 60 Hz frames |
| port_rd | input | 1 | One-cycle strobe for a read of the I/O port |
| port_wr | input | 1 | One-cycle strobe for a write of the I/O port |
| port_wdata | input | 8 | Data byte of the port write |
| int_oe | output | 1 | 1 = pull the interrupt line low, 0 = release it |
| irq_flag | output | 1 | Pending flag, shown on bit 7 of the port read data |

## Verification
Both outputs are registered, so every result appears on the edge that follows the stimulus. A strobe driven in one cycle shows its effect on `irq_flag` at the next sampling point. A frame tick detected in cycle P-1 shows `int_oe` high after edge P. The bench drives inputs and samples outputs on the falling edge. It advances its reference model on each rising edge, so every comparison falls exactly one edge after the stimulus that caused it. The directed cases place a read strobe in the cycle just before a tick, to cover R8. They also switch the rate while the divider is past the shorter terminal count, to cover R9.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
   function automatic int period_cycles(input int clk_hz, input int rate_hz);
      return clk_hz / rate_hz;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/frame_tick_div.sv
module frame_tick_div #(
   parameter int PER_A = 147456,
   parameter int PER_B = 122880,
   localparam int PER_MAX = frame_irq_pkg::max2(PER_A, PER_B),
   localparam int CW = $clog2(PER_MAX)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_b,
   output logic tick
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] term;

   generate
      if (PER_A == PER_B) begin : g_single
         assign term = CW'(PER_A - 1);
      end else begin : g_dual
         assign term = sel_b ? CW'(PER_B - 1) : CW'(PER_A - 1);
      end
   endgenerate

   // greater-or-equal lets a rate switch past the new terminal fire at once
   assign tick = (cnt >= term);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   assert_wrap_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));
   assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(PER_MAX - 1));
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
   parameter int PULSE_CLKS = 32,
   localparam int PW = $clog2(PULSE_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   logic [PW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n)          left <= '0;
      else if (start)      left <= PW'(PULSE_CLKS);
      else if (left != '0) left <= left - 1'b1;
   end

   assign active = (left != '0);

   // length of the current run, kept only for the width check
   logic [PW:0] run_len;
   always_ff @(posedge clk) begin
      if (!rst_n)      run_len <= '0;
      else if (active) run_len <= run_len + 1'b1;
      else             run_len <= '0;
   end

   assert_width_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> (run_len == (PW+1)'(PULSE_CLKS)));
   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !active);
endmodule

// File: rtl/owner_flag.sv
module owner_flag #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] CLEAR_CODE = 8'h80,
   parameter bit READ_CLEARS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic              rd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              pend
);
   logic clr;
   logic wr_hit;

   assign wr_hit = wr && (wdata == CLEAR_CODE);

   generate
      if (READ_CLEARS) begin : g_rd_clr
         assign clr = rd || wr_hit;
      end else begin : g_wr_clr
         assign clr = wr_hit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   pend <= 1'b0;
      else if (set) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend);
   assert_clear_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !set) |=> !pend);
   assert_other_write_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && wr && (wdata != CLEAR_CODE) && !rd) |=> pend);
   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (READ_CLEARS && rd && !set) |=> !pend);
endmodule

// File: rtl/frame_irq_gen.sv
module frame_irq_gen #(
   parameter int CLK_HZ     = 7372800,
   parameter int RATE_A_HZ  = 50,
   parameter int RATE_B_HZ  = 60,
   parameter int PULSE_CLKS = 32,
   parameter int DATA_W     = 8,
   localparam int PER_A   = frame_irq_pkg::period_cycles(CLK_HZ, RATE_A_HZ),
   localparam int PER_B   = frame_irq_pkg::period_cycles(CLK_HZ, RATE_B_HZ),
   localparam int PER_MIN = frame_irq_pkg::min2(PER_A, PER_B)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rate_sel,
   input  logic              port_rd,
   input  logic              port_wr,
   input  logic [DATA_W-1:0] port_wdata,
   output logic              int_oe,
   output logic              irq_flag
);
   generate
      if (PULSE_CLKS < 23) begin : g_bad_width
         $error("PULSE_CLKS must be at least 23 CPU clocks");
      end
      if (PULSE_CLKS >= PER_MIN) begin : g_bad_period
         $error("PULSE_CLKS must be shorter than the frame period");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold the 0x80 clear code");
      end
   endgenerate

   logic tick;

   frame_tick_div #(.PER_A(PER_A), .PER_B(PER_B)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_b (rate_sel),
      .tick  (tick)
   );

   irq_pulse_gen #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tick),
      .active (int_oe)
   );

   owner_flag #(.DATA_W(DATA_W), .CLEAR_CODE(DATA_W'(8'h80)), .READ_CLEARS(1'b1)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (tick),
      .rd    (port_rd),
      .wr    (port_wr),
      .wdata (port_wdata),
      .pend  (irq_flag)
   );

   assert_flag_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_oe) |-> irq_flag);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!int_oe && !irq_flag));
endmodule

// File: tb/frame_irq_gen_bench.sv
module frame_irq_gen_bench;
   localparam int CLK_HZ = 6000;
   localparam int W      = 32;
   localparam int P50    = CLK_HZ / 50;
   localparam int P60    = CLK_HZ / 60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rate_sel = 1'b0;
   logic       port_rd = 1'b0;
   logic       port_wr = 1'b0;
   logic [7:0] port_wdata = 8'h00;
   logic       int_oe;
   logic       irq_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   frame_irq_gen #(.CLK_HZ(CLK_HZ), .PULSE_CLKS(W)) u_frame_irq_gen (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .port_rd(port_rd),
      .port_wr(port_wr), .port_wdata(port_wdata), .int_oe(int_oe), .irq_flag(irq_flag)
   );

   function automatic int period_for(input logic sel);
      return sel ? P60 : P50;
   endfunction

   function automatic bit clears(input logic rd, input logic wr, input logic [7:0] d);
      return rd || (wr && d == 8'h80);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // reference model, built from the requirement text
   int m_ph = 0;
   int m_left = 0;
   bit m_pend = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_pend = 1'b0;
      end else begin
         bit t;
         t = (m_ph >= period_for(rate_sel) - 1);
         m_ph   = t ? 0 : m_ph + 1;
         m_left = t ? W : ((m_left > 0) ? m_left - 1 : 0);
         m_pend = t || (m_pend && !clears(port_rd, port_wr, port_wdata));
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(int_oe == (m_left != 0), "R2 R3 R4 int_oe", int'(int_oe), int'(m_left != 0));
         check(irq_flag == m_pend, "R5 R6 R7 irq_flag", int'(irq_flag), int'(m_pend));
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         port_rd = 1'b0; port_wr = 1'b0;
      end
   endtask

   initial begin
      int k;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(int_oe == 1'b0, "R1 int_oe in reset", int'(int_oe), 0);
      check(irq_flag == 1'b0, "R1 flag in reset", int'(irq_flag), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(int_oe == 1'b0 && irq_flag == 1'b0, "R1 after release", int'({int_oe, irq_flag}), 0);
      // R10: first pulse on edge P50
      k = 1;
      while (!int_oe && k < 4 * P50) begin @(negedge clk); k++; end
      check(k == P50, "R10 first pulse edge", k, P50);
      check(irq_flag == 1'b1, "R5 flag with pulse", int'(irq_flag), 1);
      // R7: other byte leaves flag set
      @(negedge clk); port_wr = 1'b1; port_wdata = 8'h81;
      @(negedge clk); port_wr = 1'b0;
      check(irq_flag == 1'b1, "R7 write 0x81 kept", int'(irq_flag), 1);
      port_wr = 1'b1; port_wdata = 8'h80;
      @(negedge clk); port_wr = 1'b0;
      check(irq_flag == 1'b0, "R7 write 0x80 cleared", int'(irq_flag), 0);
      // R6: read clears
      while (!(m_ph == P50 - 2)) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check(irq_flag == 1'b1, "R6 flag before read", int'(irq_flag), 1);
      port_rd = 1'b1;
      @(negedge clk); port_rd = 1'b0;
      check(irq_flag == 1'b0, "R6 read cleared", int'(irq_flag), 0);
      // R8: read in the tick cycle
      while (m_ph != P50 - 1) @(negedge clk);
      port_rd = 1'b1;
      @(negedge clk); port_rd = 1'b0;
      check(irq_flag == 1'b1, "R8 set wins over read", int'(irq_flag), 1);
      check(int_oe == 1'b1, "R8 pulse started", int'(int_oe), 1);
      // R9: shorten period while counter is past the new terminal
      while (m_ph != P60 + 5) @(negedge clk);
      rate_sel = 1'b1;
      @(negedge clk);
      check(int_oe == 1'b1, "R9 immediate pulse", int'(int_oe), 1);
      // R3: spacing at 60 Hz
      while (int_oe) @(negedge clk);
      k = 0;
      while (!int_oe && k < 4 * P50) begin @(negedge clk); k++; end
      check(k == P60 - W, "R3 gap at 60 Hz", k, P60 - W);
      // R2: spacing at 50 Hz
      rate_sel = 1'b0;
      while (int_oe) @(negedge clk);
      while (!int_oe) @(negedge clk);
      while (int_oe) @(negedge clk);
      k = 0;
      while (!int_oe && k < 4 * P50) begin @(negedge clk); k++; end
      check(k == P50 - W, "R2 gap at 50 Hz", k, P50 - W);
      // constrained random mix
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         port_rd = ($urandom_range(99) < 4);
         port_wr = ($urandom_range(99) < 4);
         port_wdata = ($urandom_range(1) == 0) ? 8'h80 : 8'($urandom);
         if ($urandom_range(999) == 0) rate_sel = ~rate_sel;
      end
      idle(2);
      // R1: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check(int_oe == 1'b0 && irq_flag == 1'b0, "R1 reset mid-run", int'({int_oe, irq_flag}), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      done = 1'b1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule